// File: doc/BRIEF.md
# Way-Predicting Set-Associative Cache Lookup

This block is the tag-lookup path of a four-way set-associative cache. Each set keeps a small prediction field that names the way most likely to hold the next line asked for in that set. After a request is accepted, the first cycle compares only the predicted way's tag, and the line data mux is already steered to that way. A correct guess completes in one cycle. When the guess is wrong, the other three ways of the set are compared in the next cycle. A match there completes in two cycles, and the prediction moves to the way that matched.

When no way matches, the block reports a miss and stalls until the next level supplies the line through a simple fill port. The fill is installed into the lowest-numbered invalid way of the set. If every way is valid, it goes to the way named by a per-set round-robin pointer. The filled way becomes the set's prediction. The surrounding pipeline sees the latency of every hit on a dedicated output, and it must not present a new request while a second-cycle compare or a miss is pending.

Top module: `wp_cache_lookup`

## Requirements
- R1: A request address is decoded with bits [3:0] as the byte offset, which never changes the result, bits [9:4] as the set index (block address modulo 64), and bits [31:10] as the tag.
- R2: After reset every way of every set is invalid, so the first request to any set produces a miss.
- R3: When the predicted way is valid and its tag matches, `hit_o` is 1 and `slow_o` is 0 in the cycle after acceptance, and `rdata_o` carries that way's line.
- R4: When the predicted way does not match but another valid way does, the first cycle after acceptance shows no hit and no miss. In the second cycle after acceptance, `hit_o` and `slow_o` are both 1 and `rdata_o` carries the matching way's line.
- R5: After a second-cycle hit, the set's prediction names the way that hit, so the next request to the same line completes in one cycle.
- R6: When no valid way matches, `miss_o` rises in the second cycle after acceptance and stays high up to and including the cycle in which `fill_valid_i` is sampled. `req_ready_o` is 1 in the following cycle.
- R7: The line given on `fill_data_i` is installed under the missed tag and set, and its way becomes the set's prediction. The next request to that line is a one-cycle hit returning the fill data.
- R8: A fill goes to the lowest-numbered invalid way of the set. If all four ways are valid, it goes to the way named by the set's round-robin pointer, which starts at way 0 and advances by one (modulo 4) after each such eviction.
- R9: `req_ready_o` is 1 when the block is idle and in the cycle of a one-cycle hit, which allows back-to-back requests. It is 0 during a mispredicted first cycle, a second-cycle compare, and a pending miss. Requests presented while it is 0 are ignored.
- R10: `fill_valid_i` has no effect unless a miss is pending.
- R11: `hit_o` and `miss_o` are never high in the same cycle, and `slow_o` is high only together with `hit_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Request present |
| req_addr_i | input | 32 | Request byte address |
| req_ready_o | output | 1 | Request accepted this cycle when valid |
| hit_o | output | 1 | Lookup hit, data valid |
| slow_o | output | 1 | Hit found in the second cycle |
| miss_o | output | 1 | No way matched; waiting for fill |
| rdata_o | output | 128 | Line data of the hitting way |
| fill_valid_i | input | 1 | Fill line present |
| fill_data_i | input | 128 | Fill line data |

## Verification
The assertions take for granted two things about the inputs. Requests are presented only while `req_ready_o` is high, or else are meant to be dropped. A fill answers only the one miss that is pending. The stimulus raises `req_valid_i` during a busy state only to deliberately test that the request is ignored, with an address the design must not act on. It pulses `fill_valid_i` outside a pending miss only to test that the pulse is ignored. A reference model in the bench tracks valid bits, tags, predictions and round-robin pointers according to the requirements. The sweep walks every set through cold misses, mispredictions, back-to-back hits and evictions with all ways full, and varies the byte offset and the fill delay.

// File: rtl/wpc_pkg.sv
package wpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_PROBE = 2'd1,
    ST_SWEEP = 2'd2,
    ST_WAIT  = 2'd3
  } wpc_state_e;
endpackage

// File: rtl/wpc_addr_split.sv
module wpc_addr_split #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 4,
  parameter int IDX_W  = 6,
  localparam int TAG_W = ADDR_W - IDX_W - OFF_W
) (
  input  logic [ADDR_W-OFF_W-1:0] blk_addr_i,
  output logic [TAG_W-1:0]        tag_o,
  output logic [IDX_W-1:0]        idx_o
);
  // index = block address modulo set count (power of two)
  assign idx_o = blk_addr_i[IDX_W-1:0];
  assign tag_o = blk_addr_i[ADDR_W-OFF_W-1:IDX_W];
endmodule

// File: rtl/wpc_way_store.sv
module wpc_way_store #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 22,
  parameter int LINE_W = 128,
  localparam int SETS  = 1 << IDX_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  input  logic              wr_en_i,
  input  logic [IDX_W-1:0]  wr_idx_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_data_i,
  output logic              rd_valid_o,
  output logic [TAG_W-1:0]  rd_tag_o,
  output logic [LINE_W-1:0] rd_data_o
);
  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_mem  [SETS];
  logic [LINE_W-1:0] data_mem [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      valid_q <= '0;
    else if (wr_en_i) valid_q[wr_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_mem[wr_idx_i]  <= wr_tag_i;
      data_mem[wr_idx_i] <= wr_data_i;
    end
  end

  assign rd_valid_o = valid_q[rd_idx_i];
  assign rd_tag_o   = tag_mem[rd_idx_i];
  assign rd_data_o  = data_mem[rd_idx_i];
endmodule

// File: rtl/wpc_victim_sel.sv
module wpc_victim_sel #(
  parameter int WAYS   = 4,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]  valid_i,
  input  logic [WAY_W-1:0] rr_i,
  output logic [WAY_W-1:0] victim_o,
  output logic             all_valid_o
);
  assign all_valid_o = &valid_i;

  always_comb begin
    victim_o = rr_i;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid_i[w]) victim_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wp_cache_lookup.sv
module wp_cache_lookup #(
  parameter int ADDR_W     = 32,
  parameter int SETS       = 64,
  parameter int WAYS       = 4,
  parameter int LINE_BYTES = 16,
  localparam int OFF_W  = $clog2(LINE_BYTES),
  localparam int IDX_W  = $clog2(SETS),
  localparam int TAG_W  = ADDR_W - IDX_W - OFF_W,
  localparam int WAY_W  = $clog2(WAYS),
  localparam int LINE_W = 8 * LINE_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              hit_o,
  output logic              slow_o,
  output logic              miss_o,
  output logic [LINE_W-1:0] rdata_o,
  input  logic              fill_valid_i,
  input  logic [LINE_W-1:0] fill_data_i
);
  import wpc_pkg::*;

  wpc_state_e        state_q, state_d;
  logic [TAG_W-1:0]  tag_q, req_tag;
  logic [IDX_W-1:0]  idx_q, req_idx;
  logic [WAY_W-1:0]  pred_q [SETS];
  logic [WAY_W-1:0]  rr_q   [SETS];

  logic [WAYS-1:0]   way_valid;
  logic [TAG_W-1:0]  way_tag  [WAYS];
  logic [LINE_W-1:0] way_data [WAYS];
  logic [WAYS-1:0]   other_match;

  logic [WAY_W-1:0]  pred_way, hit_way, victim;
  logic              pred_hit, sweep_hit, all_valid;
  logic              accept, fill_we;
  logic              unused_off;

  assign unused_off = ^req_addr_i[OFF_W-1:0];

  wpc_addr_split #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .IDX_W(IDX_W)) u_split (
    .blk_addr_i (req_addr_i[ADDR_W-1:OFF_W]),
    .tag_o      (req_tag),
    .idx_o      (req_idx)
  );

  assign fill_we = (state_q == ST_WAIT) && fill_valid_i;

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    wpc_way_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_store (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rd_idx_i   (idx_q),
      .wr_en_i    (fill_we && (victim == WAY_W'(w))),
      .wr_idx_i   (idx_q),
      .wr_tag_i   (tag_q),
      .wr_data_i  (fill_data_i),
      .rd_valid_o (way_valid[w]),
      .rd_tag_o   (way_tag[w]),
      .rd_data_o  (way_data[w])
    );
    // second-cycle compare covers every way except the predicted one
    assign other_match[w] = way_valid[w] && (way_tag[w] == tag_q) && (pred_way != WAY_W'(w));
  end

  wpc_victim_sel #(.WAYS(WAYS)) u_victim (
    .valid_i     (way_valid),
    .rr_i        (rr_q[idx_q]),
    .victim_o    (victim),
    .all_valid_o (all_valid)
  );

  // first cycle: single compare on the predicted way only
  assign pred_way  = pred_q[idx_q];
  assign pred_hit  = way_valid[pred_way] && (way_tag[pred_way] == tag_q);
  assign sweep_hit = |other_match;

  always_comb begin
    hit_way = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (other_match[w]) hit_way = WAY_W'(w);
    end
  end

  assign rdata_o     = way_data[(state_q == ST_SWEEP) ? hit_way : pred_way];
  assign hit_o       = ((state_q == ST_PROBE) && pred_hit) || ((state_q == ST_SWEEP) && sweep_hit);
  assign slow_o      = (state_q == ST_SWEEP) && sweep_hit;
  assign miss_o      = ((state_q == ST_SWEEP) && !sweep_hit) || (state_q == ST_WAIT);
  assign req_ready_o = (state_q == ST_IDLE) || ((state_q == ST_PROBE) && pred_hit);
  assign accept      = req_valid_i && req_ready_o;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_PROBE;
      ST_PROBE: state_d = pred_hit ? (accept ? ST_PROBE : ST_IDLE) : ST_SWEEP;
      ST_SWEEP: state_d = sweep_hit ? ST_IDLE : ST_WAIT;
      ST_WAIT:  if (fill_valid_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      tag_q   <= '0;
      idx_q   <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        tag_q <= req_tag;
        idx_q <= req_idx;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < SETS; s++) begin
        pred_q[s] <= '0;
        rr_q[s]   <= '0;
      end
    end else begin
      if ((state_q == ST_SWEEP) && sweep_hit) pred_q[idx_q] <= hit_way;
      if (fill_we) begin
        pred_q[idx_q] <= victim;
        if (all_valid) rr_q[idx_q] <= rr_q[idx_q] + 1'b1;
      end
    end
  end
endmodule

// File: rtl/wpc_checker.sv
module wpc_checker (
  input logic clk_i,
  input logic rst_ni,
  input logic req_valid_i,
  input logic req_ready_o,
  input logic hit_o,
  input logic slow_o,
  input logic miss_o,
  input logic fill_valid_i
);
  AST_HIT_MISS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(hit_o && miss_o)); // R11

  AST_SLOW_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_o |-> hit_o); // R11

  AST_FAST_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_o && !slow_o) |-> $past(req_valid_i && req_ready_o)); // R3

  AST_SLOW_AFTER_MISPREDICT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    slow_o |-> $past(!req_ready_o && !hit_o && !miss_o)); // R4

  AST_MISS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_o && !fill_valid_i) |=> miss_o); // R6

  AST_FILL_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (miss_o && fill_valid_i && $past(miss_o)) |=> (req_ready_o && !miss_o)); // R6

  AST_BUSY_NOT_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slow_o || miss_o) |-> !req_ready_o); // R9
endmodule

bind wp_cache_lookup wpc_checker u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .req_valid_i  (req_valid_i),
  .req_ready_o  (req_ready_o),
  .hit_o        (hit_o),
  .slow_o       (slow_o),
  .miss_o       (miss_o),
  .fill_valid_i (fill_valid_i)
);

// File: tb/sim_wp_cache_lookup.sv
`timescale 1ns/1ps
module sim_wp_cache_lookup;
  logic         clk_i = 1'b0;
  logic         rst_ni = 1'b0;
  logic         req_valid_i = 1'b0;
  logic [31:0]  req_addr_i = '0;
  logic         req_ready_o, hit_o, slow_o, miss_o;
  logic [127:0] rdata_o;
  logic         fill_valid_i = 1'b0;
  logic [127:0] fill_data_i = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  // reference model state
  bit          m_valid [64][4];
  logic [21:0] m_tag   [64][4];
  int          m_pred  [64];
  int          m_rr    [64];

  always #10 clk_i = ~clk_i;

  wp_cache_lookup u0 (
    .clk_i, .rst_ni, .req_valid_i, .req_addr_i, .req_ready_o,
    .hit_o, .slow_o, .miss_o, .rdata_o, .fill_valid_i, .fill_data_i
  );

  function automatic logic [127:0] line_data(logic [21:0] t, logic [5:0] i);
    logic [31:0] la;
    la = {t, i, 4'h0};
    return {la ^ 32'h5A5A_0F0F, ~la, la * 32'd2654435761, la + 32'h1357_9BDF};
  endfunction

  task automatic chk(bit ok, string req, string what, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic idle_check(string req);
    chk(!hit_o && !miss_o && req_ready_o, req, "idle outputs {hit,miss,ready}",
        {hit_o, miss_o, req_ready_o}, 3'b001);
  endtask

  // one request, model-predicted outcome; starts and ends at a negedge with the block idle
  task automatic access(logic [21:0] t, logic [5:0] i, logic [3:0] off, int wait_cyc, string fast_lbl);
    int  kind, way, filled;
    bit  full;
    kind = 2; way = 0; filled = 0;
    for (int w = 0; w < 4; w++) if (m_valid[i][w]) filled++;
    full = (filled == 4);
    if (m_valid[i][m_pred[i]] && m_tag[i][m_pred[i]] == t) begin
      kind = 0; way = m_pred[i];
    end else begin
      for (int w = 3; w >= 0; w--)
        if (w != m_pred[i] && m_valid[i][w] && m_tag[i][w] == t) begin kind = 1; way = w; end
    end

    chk(req_ready_o, "R9", "ready before request", req_ready_o, 1);
    req_valid_i = 1'b1;
    req_addr_i  = {t, i, off};
    @(posedge clk_i); @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(!(hit_o && miss_o), "R11", "hit and miss together", {hit_o, miss_o}, 2'b00);
    if (kind == 0) begin
      chk(hit_o && !slow_o && !miss_o, fast_lbl, "first-cycle {hit,slow,miss}",
          {hit_o, slow_o, miss_o}, 3'b100);
      chk(rdata_o == line_data(t, i), fast_lbl, "first-cycle data", rdata_o, line_data(t, i));
      @(posedge clk_i); @(negedge clk_i);
    end else begin
      chk(!hit_o && !miss_o && !req_ready_o, (filled == 0) ? "R2" : "R4",
          "mispredict cycle {hit,miss,ready}", {hit_o, miss_o, req_ready_o}, 3'b000);
      // stray request while busy: must be dropped
      req_valid_i = 1'b1;
      req_addr_i  = {t ^ 22'h1, i, off};
      @(posedge clk_i); @(negedge clk_i);
      chk(!req_ready_o, "R9", "ready during second cycle", req_ready_o, 0);
      req_valid_i = 1'b0;
      if (kind == 1) begin
        chk(hit_o && slow_o && !miss_o, "R4", "second-cycle {hit,slow,miss}",
            {hit_o, slow_o, miss_o}, 3'b110);
        chk(rdata_o == line_data(t, i), "R4", "second-cycle data", rdata_o, line_data(t, i));
        m_pred[i] = way;
        @(posedge clk_i); @(negedge clk_i);
      end else begin
        chk(miss_o && !hit_o, full ? "R8" : "R6", "second-cycle miss {hit,miss}",
            {hit_o, miss_o}, 2'b01);
        @(posedge clk_i); @(negedge clk_i);
        for (int c = 0; c < wait_cyc; c++) begin
          chk(miss_o && !req_ready_o, "R6", "miss held while waiting", {miss_o, req_ready_o}, 2'b10);
          @(posedge clk_i); @(negedge clk_i);
        end
        fill_valid_i = 1'b1;
        fill_data_i  = line_data(t, i);
        chk(miss_o, "R6", "miss in fill cycle", miss_o, 1);
        @(posedge clk_i); @(negedge clk_i);
        fill_valid_i = 1'b0;
        fill_data_i  = '0;
        chk(req_ready_o && !miss_o, "R6", "released after fill {ready,miss}",
            {req_ready_o, miss_o}, 2'b10);
        way = -1;
        for (int w = 3; w >= 0; w--) if (!m_valid[i][w]) way = w;
        if (way < 0) begin
          way = m_rr[i];
          m_rr[i] = (m_rr[i] + 1) % 4;
        end
        m_valid[i][way] = 1'b1;
        m_tag[i][way]   = t;
        m_pred[i]       = way;
      end
    end
    idle_check("R9");
  endtask

  task automatic back_to_back(logic [21:0] ta, logic [5:0] ia, logic [21:0] tb, logic [5:0] ib);
    req_valid_i = 1'b1;
    req_addr_i  = {ta, ia, 4'h3};
    @(posedge clk_i); @(negedge clk_i);
    chk(hit_o && !slow_o, "R3", "b2b first {hit,slow}", {hit_o, slow_o}, 2'b10);
    chk(rdata_o == line_data(ta, ia), "R3", "b2b first data", rdata_o, line_data(ta, ia));
    chk(req_ready_o, "R9", "ready during fast hit", req_ready_o, 1);
    req_addr_i = {tb, ib, 4'hC};
    @(posedge clk_i); @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(hit_o && !slow_o, "R9", "b2b second {hit,slow}", {hit_o, slow_o}, 2'b10);
    chk(rdata_o == line_data(tb, ib), "R9", "b2b second data", rdata_o, line_data(tb, ib));
    @(posedge clk_i); @(negedge clk_i);
    idle_check("R9");
  endtask

  initial begin
    for (int s = 0; s < 64; s++) begin
      m_pred[s] = 0; m_rr[s] = 0;
      for (int w = 0; w < 4; w++) begin m_valid[s][w] = 1'b0; m_tag[s][w] = '0; end
    end
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    idle_check("R2");

    // R10: stray fill while idle is ignored
    fill_valid_i = 1'b1;
    fill_data_i  = line_data(22'h3FF, 6'd5);
    @(posedge clk_i); @(negedge clk_i);
    fill_valid_i = 1'b0;
    chk(!hit_o && !miss_o, "R10", "outputs after stray fill", {hit_o, miss_o}, 2'b00);
    access(22'h3FF, 6'd5, 4'h0, 0, "R10");

    // R2/R7: cold miss on every set, then refetch is fast
    for (int s = 0; s < 64; s++) access(22'(s * 3 + 1), 6'(s), 4'(s), s % 3, "R7");
    for (int s = 0; s < 64; s++) access(22'(s * 3 + 1), 6'(s), 4'(15 - s % 16), 0, "R1");

    // R8: fill ways of set 9, wrap round-robin, then check which tags survive
    for (int k = 0; k < 9; k++) access(22'h200 + 22'(k), 6'd9, 4'h0, 1, "R7");
    for (int k = 0; k < 9; k++) access(22'h200 + 22'(k), 6'd9, 4'h7, 0, "R8");

    // R4/R5: mispredict then repeat becomes fast
    access(22'h0AB, 6'd20, 4'h0, 0, "R7");
    access(22'(20 * 3 + 1), 6'd20, 4'h0, 0, "R4");
    access(22'(20 * 3 + 1), 6'd20, 4'h0, 0, "R5");

    // R3/R9: back-to-back one-cycle hits in different sets
    access(22'h055, 6'd30, 4'h0, 0, "R3");
    access(22'h066, 6'd31, 4'h0, 0, "R3");
    back_to_back(22'h055, 6'd30, 22'h066, 6'd31);

    // sweep: every set, mixed tags forcing all outcomes
    for (int s = 0; s < 64; s++)
      for (int k = 0; k < 12; k++)
        access(22'((k * 7 + s) % 9 + 1) << 8, 6'(s), 4'(k ^ s), k % 3, "R5");

    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule